// File: doc/BRIEF.md
# Free-running clock output controller with mode-dependent defaults

This block owns one 8-bit control register and uses it to drive two free-running clock outputs. The core clock runs at twice the bus rate, and a bus-clock enable marks alternate core cycles. The first output is a bus-rate clock that can be divided by 1, 2, 3 or 4. It is built from a half-period counter in the core-clock domain, so its duty cycle is always 50%. The second output is the core clock itself, at twice the bus rate, passed through a gate.

The register can be read and written in every mode. Its value after reset depends on the operating-mode input. Both emulation modes override the register: both outputs stay on, and the divider is bypassed. The register still holds whatever was written, and readback returns it unchanged.

A change to an enable bit or to the divider select takes effect only at a low boundary of the affected clock, so neither output produces a runt pulse. A disabled output is held low.

Top module: `clkout_ctrl`

## Requirements
- R1: Register bit 7 disables the bus-rate output, bit 6 disables the double-rate output, and bits 1:0 are the divider select. These three fields are writable. Bits 5:2 always read 0, so writing 0xFF reads back 0xC3 and writing 0x3C reads back 0x00.
- R2: Mode codes are 0 special single-chip, 1 emulation single-chip, 2 special test, 3 emulation expanded, 4 normal single-chip and 5 normal expanded. After reset the register reads 0xC0 in modes 1 and 4, and 0x40 in every other mode.
- R3: The register can be written and read back in every mode, including both emulation modes, whatever the overrides are doing.
- R4: Outside emulation, with bit 7 at 0 and divider select N, the bus-rate output has a period of 2(N+1) core cycles and stays high for N+1 of them.
- R5: Outside emulation, with bit 7 at 1, the bus-rate output is held low.
- R6: Outside emulation, the double-rate output follows the core clock when bit 6 is 0, and is held low when bit 6 is 1.
- R7: In modes 1 and 3, both outputs run whatever bits 7 and 6 hold.
- R8: In modes 1 and 3, the bus-rate output runs undivided (period 2 core cycles), whatever bits 1:0 hold.
- R9: A high phase of the bus-rate output that has already started always lasts its full N+1 cycles. A new enable or divider value is adopted only at the end of a low phase.
- R10: Every rising edge of the bus-rate output is launched on a core edge where the bus-clock enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Bus-clock enable, high on alternate core cycles |
| mode | input | 3 | Operating-mode code (see R2) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register readback |
| bus_clk_o | output | 1 | Divided bus-rate clock output |
| dbl_clk_o | output | 1 | Gated double-rate clock output |

## Verification
A wrong reset image shows on rd_data a few cycles after reset release, and it also shows in whether each output is running. A corrupted divider counter or phase state shows within one output period, as a wrong high length, a wrong period, or a rising edge off the bus-enable phase. The emulation override is checked by leaving the register in the state that would otherwise disable or divide the outputs, then watching both outputs run undivided. Runt-pulse protection is checked by changing the register in the middle of a high phase and timing that phase.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;
  localparam int REG_W       = 8;
  localparam int DIV_W       = 2;
  localparam int BIT_BUS_OFF = 7;
  localparam int BIT_DBL_OFF = 6;
  localparam logic [REG_W-1:0] WR_MASK = 8'hC3;

  typedef enum logic [2:0] {
    MD_SPC_SC   = 3'd0,
    MD_EMU_SC   = 3'd1,
    MD_SPC_TEST = 3'd2,
    MD_EMU_EXP  = 3'd3,
    MD_NRM_SC   = 3'd4,
    MD_NRM_EXP  = 3'd5
  } op_mode_e;

  function automatic logic is_emu(input logic [2:0] m);
    return (m == MD_EMU_SC) || (m == MD_EMU_EXP);
  endfunction

  function automatic logic [REG_W-1:0] reset_image(input logic [2:0] m);
    return ((m == MD_EMU_SC) || (m == MD_NRM_SC)) ? 8'hC0 : 8'h40;
  endfunction
endpackage

// File: rtl/clkout_rst_sync.sv
`timescale 1ns/1ps
module clkout_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/clkout_regs.sv
`timescale 1ns/1ps
module clkout_regs
  import clkout_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] ctl_q, ctl_d;
  logic             init_q;
  logic             reg_en;

  // The first clock after reset release loads the mode image; a write wins.
  always_comb begin
    reg_en = wr | ~init_q;
    if (wr) ctl_d = wdata & WR_MASK;
    else    ctl_d = reset_image(mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      init_q <= 1'b0;
    end else begin
      if (reg_en) ctl_q <= ctl_d;
      init_q <= 1'b1;
    end
  end

  assign rdata = init_q ? ctl_q : reset_image(mode);

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr) |-> ctl_q == ($past(wdata) & WR_MASK)); // R3
endmodule

// File: rtl/clkout_div.sv
`timescale 1ns/1ps
module clkout_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             run_req,
  input  logic [DIV_W-1:0] div_sel,
  output logic             clk_o
);
  localparam logic [DIV_W-1:0] CNT_ONE = 1;

  logic             out_q, out_d;
  logic             act_q, act_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             phase_end;

  assign phase_end = (cnt_q == div_q);

  always_comb begin
    out_d = out_q;
    act_d = act_q;
    div_d = div_q;
    cnt_d = cnt_q;
    if (!act_q) begin
      if (run_req && bus_en) begin
        act_d = 1'b1;
        out_d = 1'b1;
        cnt_d = '0;
        div_d = div_sel;
      end
    end else if (!phase_end) begin
      cnt_d = cnt_q + CNT_ONE;
    end else if (out_q) begin
      out_d = 1'b0;
      cnt_d = '0;
    end else if (run_req) begin
      out_d = 1'b1;
      cnt_d = '0;
      div_d = div_sel;
    end else begin
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      act_q <= 1'b0;
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      out_q <= out_d;
      act_q <= act_d;
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  assign clk_o = out_q;

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !out_q); // R5
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_q); // R4
  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q && $past(out_q)) |-> $stable(div_q)); // R9
  AST_RISE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_q) && !$past(act_q)) |-> $past(bus_en)); // R10
endmodule

// File: rtl/clkout_gate.sv
`timescale 1ns/1ps
module clkout_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  output logic clk_o
);
  logic gate_q;

  // Enable updates while clk is low, so the AND never clips a high phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= run_req;
  end

  assign clk_o = clk & gate_q;
endmodule

// File: rtl/clkout_ctrl.sv
`timescale 1ns/1ps
module clkout_ctrl
  import clkout_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic [2:0]       mode,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             bus_clk_o,
  output logic             dbl_clk_o
);
  logic             rst_s_n;
  logic [REG_W-1:0] ctl;
  logic             emu;
  logic             bus_run;
  logic             dbl_run;
  logic [DIV_W-1:0] div_eff;
  logic [BIT_DBL_OFF-1:DIV_W] ctl_unused;

  clkout_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  clkout_regs u_regs (
    .clk(clk), .rst_n(rst_s_n), .mode(mode),
    .wr(wr_en), .wdata(wr_data), .rdata(ctl));

  always_comb begin
    emu     = is_emu(mode);
    bus_run = emu | ~ctl[BIT_BUS_OFF];
    dbl_run = emu | ~ctl[BIT_DBL_OFF];
    div_eff = emu ? '0 : ctl[DIV_W-1:0];
  end

  assign ctl_unused = ctl[BIT_DBL_OFF-1:DIV_W];
  assign rd_data    = ctl;

  clkout_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_s_n), .bus_en(bus_en),
    .run_req(bus_run), .div_sel(div_eff), .clk_o(bus_clk_o));

  clkout_gate u_gate (
    .clk(clk), .rst_n(rst_s_n), .run_req(dbl_run), .clk_o(dbl_clk_o));
endmodule

// File: tb/sim_clkout_ctrl.sv
`timescale 1ns/1ps
module sim_clkout_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       bus_clk_o, dbl_clk_o;

  int errs = 0;
  int checks = 0;

  clkout_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .mode(mode),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .bus_clk_o(bus_clk_o), .dbl_clk_o(dbl_clk_o));

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      bus_en = ~bus_en;
    end
  end

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    $display("FAIL watchdog actual=timeout expected=completion");
    errs++;
    checks++;
    report();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sample point: 1 ns after the rising edge, clk still high.
  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic apply_reset(input logic [2:0] m);
    mode = m;
    wr_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
  endtask

  task automatic write_reg(input logic [7:0] v);
    wr_en = 1'b1;
    wr_data = v;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic measure(input int n, output int per, output int hi,
                         output int rises, output int misal);
    bit prev;
    int last;
    int hrun;
    per = -1; hi = -1; rises = 0; misal = 0; last = -1; hrun = 0;
    prev = bus_clk_o;
    for (int i = 0; i < n; i++) begin
      tick();
      if (bus_clk_o && !prev) begin
        rises++;
        if (!bus_en) misal++;
        if (last >= 0) per = i - last;
        last = i;
      end
      if (bus_clk_o) hrun++;
      else if (prev && last >= 0 && rises >= 1) begin
        hi = hrun;
        hrun = 0;
      end else hrun = 0;
      prev = bus_clk_o;
    end
  endtask

  task automatic dbl_highs(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (dbl_clk_o) h++;
    end
  endtask

  initial begin
    int per, hi, rises, misal, h, hrun;
    logic [7:0] exp_rst;

    // R2 reset image per mode, R3 write/read in every mode
    for (int m = 0; m < 6; m++) begin
      apply_reset(m[2:0]);
      exp_rst = (m == 1 || m == 4) ? 8'hC0 : 8'h40;
      chk(rd_data == exp_rst, "R2 reset image", rd_data, exp_rst);
      write_reg(8'h42);
      tick();
      chk(rd_data == 8'h42, "R3 write/read", rd_data, 8'h42);
    end

    // R1 field layout
    apply_reset(3'd0);
    write_reg(8'hFF);
    tick();
    chk(rd_data == 8'hC3, "R1 writable bits", rd_data, 8'hC3);
    write_reg(8'h3C);
    tick();
    chk(rd_data == 8'h00, "R1 reserved read zero", rd_data, 8'h00);

    // Normal single-chip: both outputs off after reset
    apply_reset(3'd4);
    repeat (10) tick();
    measure(20, per, hi, rises, misal);
    chk(rises == 0 && !bus_clk_o, "R5 bus off after reset", rises, 0);
    dbl_highs(8, h);
    chk(h == 0, "R6 dbl off after reset", h, 0);

    // R4 all divider settings, R10 alignment, R6 dbl on
    for (int n = 0; n < 4; n++) begin
      write_reg(n[7:0]);
      repeat (12) tick();
      measure(40, per, hi, rises, misal);
      chk(per == 2 * (n + 1), "R4 period", per, 2 * (n + 1));
      chk(hi == n + 1, "R4 high length", hi, n + 1);
      chk(misal == 0 && rises > 0, "R10 rise on bus_en", misal, 0);
      dbl_highs(8, h);
      chk(h == 8, "R6 dbl running", h, 8);
    end

    // R5 bus disabled, dbl still on
    write_reg(8'h80);
    repeat (12) tick();
    measure(20, per, hi, rises, misal);
    chk(rises == 0 && !bus_clk_o, "R5 bus held low", rises, 0);
    dbl_highs(8, h);
    chk(h == 8, "R6 dbl independent of bit 7", h, 8);

    // R6 dbl disabled, bus still on
    write_reg(8'h40);
    repeat (12) tick();
    dbl_highs(8, h);
    chk(h == 0, "R6 dbl held low", h, 0);
    measure(20, per, hi, rises, misal);
    chk(per == 2, "R6 bus unaffected by bit 6", per, 2);

    // R7/R8 emulation single-chip: reset image 0xC0 would disable both
    apply_reset(3'd1);
    repeat (6) tick();
    measure(20, per, hi, rises, misal);
    chk(per == 2 && hi == 1, "R7 emu bus forced on", per, 2);
    dbl_highs(8, h);
    chk(h == 8, "R7 emu dbl forced on", h, 8);
    write_reg(8'hC3);
    repeat (12) tick();
    measure(20, per, hi, rises, misal);
    chk(per == 2, "R8 emu divider bypass", per, 2);
    chk(rd_data == 8'hC3, "R3 emu readback", rd_data, 8'hC3);
    mode = 3'd3;
    repeat (12) tick();
    measure(20, per, hi, rises, misal);
    chk(per == 2 && hi == 1, "R8 emu expanded bypass", per, 2);
    dbl_highs(8, h);
    chk(h == 8, "R7 emu expanded dbl on", h, 8);
    mode = 3'd5;
    repeat (12) tick();
    measure(20, per, hi, rises, misal);
    chk(rises == 0, "R5 override released", rises, 0);

    // R9 mid-high change keeps the full high phase
    write_reg(8'h03);
    repeat (12) tick();
    hrun = 0;
    for (int i = 0; i < 40 && hrun == 0; i++) begin
      bit prev;
      prev = bus_clk_o;
      tick();
      if (bus_clk_o && !prev) hrun = 1;
    end
    write_reg(8'h80);
    if (bus_clk_o) hrun++;
    for (int i = 0; i < 10 && bus_clk_o; i++) begin
      tick();
      if (bus_clk_o) hrun++;
    end
    chk(hrun == 4, "R9 high phase completes", hrun, 4);
    measure(20, per, hi, rises, misal);
    chk(rises == 0, "R9 disable adopted after low", rises, 0);
    write_reg(8'h00);
    repeat (6) tick();
    measure(20, per, hi, rises, misal);
    chk(per == 2 && misal == 0, "R10 restart aligned", per, 2);

    report();
  end
endmodule